// File: doc/BRIEF.md
# EEPROM Write-Protect and Status Controller

This block sits behind the serial command decoder of a small serial EEPROM. It keeps the non-volatile part of the status byte: a protect-enable bit and a two-bit block-protect code. It also keeps the write-enable latch and a busy flag. It decides whether each requested status write or memory write may go ahead, and it produces the status byte that the front end shifts out on a status read.

Commands arrive as single-cycle pulses that the decoder raises while chip select is low. A status write or a memory write that passes its checks is held as pending. When chip select rises, a pending write is granted: a one-cycle grant pulse is issued and the busy flag is set. The write stays granted until the array controller pulses the cycle-done input. A rejected request produces a one-cycle inhibit pulse instead of a grant.

The block has no back-pressure. A command pulse is taken or rejected in the cycle it is seen, grants and inhibits are single-cycle outputs with no ready, and the status byte is a plain level. The protect pin is expected to be synchronised to the block clock already.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and no grant or inhibit pulse is active.
- R2: An enable-write pulse sets the write-enable latch (status bit 1) and a disable-write pulse clears it, visible the cycle after the pulse.
- R3: A status write or memory write seen while the write-enable latch is 0 gives an inhibit pulse on the next cycle, no grant at chip-select rise, and no change to the status byte.
- R4: A granted status write takes data bit 7 into the protect-enable bit and data bits 3:2 into the block-protect code when the cycle completes. Data bits 6:4 and 1:0 are ignored, and status bits 6:4 always read 0.
- R5: With the protect pin low and the protect-enable bit set, a status write is inhibited when it is seen.
- R6: With the protect-enable bit set, a fall of the protect pin while chip select is still low cancels a pending status write: an inhibit pulse follows, and no grant is issued at chip-select rise.
- R7: A fall of the protect pin after a status write has been granted does not stop that write from taking effect.
- R8: With the protect-enable bit 0, the protect pin level and its edges have no effect on status writes.
- R9: The busy flag (status bit 0) is 1 from the cycle of the grant pulse until the cycle after the cycle-done pulse. Status writes cannot change it, and a cycle-done pulse while not busy does nothing.
- R10: The write-enable latch clears when a granted write cycle completes.
- R11: A memory write is inhibited when the block-protect code is 01 and the address is in the top quarter, when the code is 10 and the address is in the top half, and when the code is 11 for any address. A code of 00 protects nothing.
- R12: While busy, every command is ignored: status and memory writes are inhibited, and enable or disable pulses leave the latch unchanged.
- R13: A grant pulse comes only in the cycle after a chip-select rise finds a pending write, and at most one grant is issued per pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select level, low while a command frame is open |
| wp_level | input | 1 | Synchronised protect-pin level, low requests protection |
| cmd_wren | input | 1 | Enable-write command pulse |
| cmd_wrdi | input | 1 | Disable-write command pulse |
| cmd_wrsr | input | 1 | Status-write command pulse |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_mwr | input | 1 | Memory-write command pulse |
| mwr_addr | input | ADDR_W | Target address of the memory write |
| cyc_done | input | 1 | Internal write cycle finished |
| status_o | output | 8 | Status byte {penable, 000, bp[1:0], wel, busy} |
| sr_grant | output | 1 | Status write granted and started |
| sr_inhibit | output | 1 | Status write rejected or cancelled |
| mem_grant | output | 1 | Memory write granted and started |
| mem_inhibit | output | 1 | Memory write rejected |

## Verification
The bench targets the protect-pin races. A pin fall while the frame is open must cancel the status write. A fall after the grant must not, so a design that checks the pin level at the chip-select rise, or at cycle completion, loses a write it should keep. With protect-enable clear the pin must be ignored, so a design that lets the pin act on its own blocks writes it should allow. The block-protect table is walked at the exact quarter and half boundaries, where an off-by-one address compare either opens a protected row or blocks a free one. The bench also sends commands while busy and a stray cycle-done, which catch a latch that can be toggled mid-cycle and a busy flag that software can write.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_SR   = 2'd1,
    PEND_MEM  = 2'd2
  } pend_e;

  localparam int SR_W       = 8;
  localparam int SR_PEN_BIT = 7;
  localparam int SR_BP_HI   = 3;
  localparam int SR_BP_LO   = 2;

  typedef struct packed {
    logic       penable;
    logic [1:0] bp;
  } sr_nv_t;

  function automatic sr_nv_t nv_from_byte(input logic [SR_W-1:0] b);
    sr_nv_t r;
    r.penable = b[SR_PEN_BIT];
    r.bp      = b[SR_BP_HI:SR_BP_LO];
    return r;
  endfunction

  function automatic logic [SR_W-1:0] pack_status(input sr_nv_t nv,
                                                  input logic wel,
                                                  input logic busy);
    return {nv.penable, 3'b000, nv.bp, wel, busy};
  endfunction

endpackage

// File: rtl/wpc_bp_check.sv
module wpc_bp_check #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  generate
    if (ADDR_W >= 2) begin : g_split
      logic [1:0] top2;
      assign top2 = addr[ADDR_W-1 -: 2];
      always_comb begin
        unique case (bp)
          2'b00:   blocked = 1'b0;
          2'b01:   blocked = (top2 == 2'b11);
          2'b10:   blocked = top2[1];
          default: blocked = 1'b1;
        endcase
      end
    end else begin : g_tiny
      logic unused_addr;
      assign unused_addr = ^addr;
      assign blocked     = (bp != 2'b00);
    end
  endgenerate
endmodule

// File: rtl/wpc_gate.sv
module wpc_gate (
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_wrsr,
  input  logic cmd_mwr,
  input  logic busy,
  input  logic wel,
  input  logic hw_lock,
  input  logic mem_blocked,
  output logic wren_ok,
  output logic wrdi_ok,
  output logic sr_ok,
  output logic sr_rej,
  output logic mem_ok,
  output logic mem_rej
);
  logic sr_fail, mem_fail;

  always_comb begin
    sr_fail  = busy | ~wel | hw_lock;
    mem_fail = busy | ~wel | mem_blocked;
    wren_ok  = cmd_wren & ~busy;
    wrdi_ok  = cmd_wrdi & ~busy;
    sr_ok    = cmd_wrsr & ~sr_fail;
    sr_rej   = cmd_wrsr &  sr_fail;
    mem_ok   = cmd_mwr  & ~mem_fail;
    mem_rej  = cmd_mwr  &  mem_fail;
  end
endmodule

// File: rtl/wpc_wel.sv
module wpc_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/wpc_cycle.sv
module wpc_cycle
  import wpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_sr,
  input  logic   load_mem,
  input  sr_nv_t sr_data,
  input  logic   abort_i,
  input  logic   commit_i,
  input  logic   done_i,
  output logic   busy_o,
  output logic   sr_go_o,
  output logic   mem_go_o,
  output logic   cancel_o,
  output logic   apply_o,
  output sr_nv_t stage_o
);
  pend_e pend_q;
  pend_e kind_q;

  assign cancel_o = (pend_q == PEND_SR) & abort_i;
  assign apply_o  = done_i & busy_o & (kind_q == PEND_SR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= PEND_NONE;
      kind_q   <= PEND_NONE;
      busy_o   <= 1'b0;
      sr_go_o  <= 1'b0;
      mem_go_o <= 1'b0;
      stage_o  <= '0;
    end else begin
      sr_go_o  <= 1'b0;
      mem_go_o <= 1'b0;
      if (commit_i) begin
        if (pend_q != PEND_NONE) begin
          busy_o   <= 1'b1;
          kind_q   <= pend_q;
          sr_go_o  <= (pend_q == PEND_SR);
          mem_go_o <= (pend_q == PEND_MEM);
        end
        pend_q <= PEND_NONE;
      end else if (cancel_o) begin
        pend_q <= PEND_NONE;
      end else if (load_sr) begin
        pend_q  <= PEND_SR;
        stage_o <= sr_data;
      end else if (load_mem) begin
        pend_q <= PEND_MEM;
      end
      if (done_i && busy_o) begin
        busy_o <= 1'b0;
        kind_q <= PEND_NONE;
      end
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_level,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [SR_W-1:0]   wrsr_data,
  input  logic              cmd_mwr,
  input  logic [ADDR_W-1:0] mwr_addr,
  input  logic              cyc_done,
  output logic [SR_W-1:0]   status_o,
  output logic              sr_grant,
  output logic              sr_inhibit,
  output logic              mem_grant,
  output logic              mem_inhibit
);
  logic   cs_q, wp_q, cs_rise, wp_fall;
  sr_nv_t nv_q, stage;
  logic   wel, busy, hw_lock, blocked, abort;
  logic   wren_ok, wrdi_ok, sr_ok, sr_rej, mem_ok, mem_rej;
  logic   cancel, apply;
  logic   unused_bits;

  assign unused_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      wp_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
      wp_q <= wp_level;
    end
  end

  assign cs_rise = cs_n & ~cs_q;
  assign wp_fall = ~wp_level & wp_q;
  assign hw_lock = nv_q.penable & ~wp_level;
  assign abort   = wp_fall & nv_q.penable & ~cs_n;

  wpc_bp_check #(.ADDR_W(ADDR_W)) u_bp (
    .bp      (nv_q.bp),
    .addr    (mwr_addr),
    .blocked (blocked)
  );

  wpc_gate u_gate (
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .cmd_wrsr    (cmd_wrsr),
    .cmd_mwr     (cmd_mwr),
    .busy        (busy),
    .wel         (wel),
    .hw_lock     (hw_lock),
    .mem_blocked (blocked),
    .wren_ok     (wren_ok),
    .wrdi_ok     (wrdi_ok),
    .sr_ok       (sr_ok),
    .sr_rej      (sr_rej),
    .mem_ok      (mem_ok),
    .mem_rej     (mem_rej)
  );

  wpc_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wren_ok),
    .clr_i (wrdi_ok | (cyc_done & busy)),
    .wel_o (wel)
  );

  wpc_cycle u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_sr  (sr_ok),
    .load_mem (mem_ok),
    .sr_data  (nv_from_byte(wrsr_data)),
    .abort_i  (abort),
    .commit_i (cs_rise),
    .done_i   (cyc_done),
    .busy_o   (busy),
    .sr_go_o  (sr_grant),
    .mem_go_o (mem_grant),
    .cancel_o (cancel),
    .apply_o  (apply),
    .stage_o  (stage)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q        <= '0;
      sr_inhibit  <= 1'b0;
      mem_inhibit <= 1'b0;
    end else begin
      if (apply) nv_q <= stage;
      sr_inhibit  <= sr_rej | cancel;
      mem_inhibit <= mem_rej;
    end
  end

  assign status_o = pack_status(nv_q, wel, busy);
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_level,
  input logic       cmd_wren,
  input logic       cmd_wrsr,
  input logic       cmd_mwr,
  input logic       cyc_done,
  input logic [7:0] status_o,
  input logic       sr_grant,
  input logic       sr_inhibit,
  input logic       mem_grant,
  input logic       mem_inhibit
);
  logic c1, c2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= 1'b1;
      c2 <= 1'b1;
    end else begin
      c1 <= cs_n;
      c2 <= c1;
    end
  end

  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !status_o[0]) |=> status_o[1]);

  assert_wel_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !status_o[1]) |=> sr_inhibit);

  assert_pin_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status_o[7] && !wp_level) |=> sr_inhibit);

  assert_busy_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant || mem_grant) |-> status_o[0]);

  assert_wel_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && status_o[0]) |=> !status_o[1]);

  assert_full_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mwr && status_o[3:2] == 2'b11) |=> mem_inhibit);

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mwr && status_o[0]) |=> mem_inhibit);

  assert_grant_after_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant || mem_grant) |-> (c1 && !c2));

  assert_one_grant_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_grant && mem_grant));
endmodule

bind eeprom_wp_ctrl wpc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .wp_level    (wp_level),
  .cmd_wren    (cmd_wren),
  .cmd_wrsr    (cmd_wrsr),
  .cmd_mwr     (cmd_mwr),
  .cyc_done    (cyc_done),
  .status_o    (status_o),
  .sr_grant    (sr_grant),
  .sr_inhibit  (sr_inhibit),
  .mem_grant   (mem_grant),
  .mem_inhibit (mem_inhibit)
);

// File: tb/sim_eeprom_wp_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_wp_ctrl;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wp_level = 1'b1;
  logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_mwr = 1'b0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] mwr_addr = '0;
  logic cyc_done = 1'b0;
  logic [7:0] status_o;
  logic sr_grant, sr_inhibit, mem_grant, mem_inhibit;
  logic g_sr, g_mem;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  eeprom_wp_ctrl #(.ADDR_W(AW)) u0 (.*);

  // vector: {blocked, bp[1:0], addr[12:0]}
  localparam logic [15:0] VEC [12] = '{
    16'h1FFF, 16'h37FF, 16'hB800, 16'hBFFF, 16'h4FFF, 16'hD000,
    16'hE000, 16'hEFFF, 16'h0000, 16'h2000, 16'hD800, 16'h4000
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wren();
    @(negedge clk) cs_n = 1'b0; cmd_wren = 1'b1;
    @(negedge clk) cmd_wren = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_wrdi();
    @(negedge clk) cs_n = 1'b0; cmd_wrdi = 1'b1;
    @(negedge clk) cmd_wrdi = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_wrsr(input logic [7:0] d);
    @(negedge clk) cs_n = 1'b0; cmd_wrsr = 1'b1; wrsr_data = d;
    @(negedge clk) cmd_wrsr = 1'b0;
  endtask

  task automatic start_mwr(input logic [AW-1:0] a);
    @(negedge clk) cs_n = 1'b0; cmd_mwr = 1'b1; mwr_addr = a;
    @(negedge clk) cmd_mwr = 1'b0;
  endtask

  task automatic release_cs();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) g_sr = sr_grant; g_mem = mem_grant;
  endtask

  task automatic finish_cycle();
    @(negedge clk) cyc_done = 1'b1;
    @(negedge clk) cyc_done = 1'b0;
  endtask

  task automatic write_status(input logic [7:0] d);
    do_wren();
    start_wrsr(d);
    release_cs();
    if (g_sr) finish_cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 8'h00);
    chk("R1 pulses", {sr_grant, sr_inhibit, mem_grant, mem_inhibit}, 4'h0);

    // R3 status write without latch
    start_wrsr(8'h8C);
    chk("R3 sr inhibit", sr_inhibit, 1'b1);
    release_cs();
    chk("R3 no grant", g_sr, 1'b0);
    chk("R3 status kept", status_o, 8'h00);

    // R2 latch set/clear
    do_wren();
    chk("R2 wren", status_o, 8'h02);
    do_wrdi();
    chk("R2 wrdi", status_o, 8'h00);

    // R4 R9 R13 R12 R10: grant, busy, ignored commands, completion
    do_wren();
    start_wrsr(8'hFF);
    chk("R4 accepted", sr_inhibit, 1'b0);
    chk("R13 no grant while cs low", sr_grant, 1'b0);
    release_cs();
    chk("R13 grant at rise", g_sr, 1'b1);
    chk("R9 busy", status_o, 8'h03);
    @(negedge clk);
    chk("R13 single grant", sr_grant, 1'b0);
    @(negedge clk) cs_n = 1'b0; cmd_wrdi = 1'b1;
    @(negedge clk) cmd_wrdi = 1'b0;
    chk("R12 wrdi ignored", status_o, 8'h03);
    start_mwr('0);
    chk("R12 mem inhibited while busy", mem_inhibit, 1'b1);
    release_cs();
    chk("R12 no mem grant", g_mem, 1'b0);
    finish_cycle();
    chk("R4 R10 applied", status_o, 8'h8C);

    // R5 pin low with protect enabled
    wp_level = 1'b0;
    do_wren();
    start_wrsr(8'h00);
    chk("R5 inhibited", sr_inhibit, 1'b1);
    release_cs();
    chk("R5 no grant", g_sr, 1'b0);
    chk("R5 status kept", status_o, 8'h8E);
    do_wrdi();
    wp_level = 1'b1;

    // R6 pin fall while frame open
    do_wren();
    start_wrsr(8'h80);
    chk("R6 accepted first", sr_inhibit, 1'b0);
    wp_level = 1'b0;
    @(negedge clk);
    chk("R6 cancel pulse", sr_inhibit, 1'b1);
    release_cs();
    chk("R6 no grant", g_sr, 1'b0);
    chk("R6 status kept", status_o, 8'h8E);
    wp_level = 1'b1;

    // R7 pin fall after grant
    start_wrsr(8'h80);
    release_cs();
    chk("R7 grant", g_sr, 1'b1);
    wp_level = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 busy", status_o, 8'h8F);
    finish_cycle();
    chk("R7 applied", status_o, 8'h80);
    wp_level = 1'b1;

    // R8 protect disabled: pin ignored
    write_status(8'h00);
    chk("R8 clear penable", status_o, 8'h00);
    wp_level = 1'b0;
    do_wren();
    start_wrsr(8'h04);
    chk("R8 pin low no inhibit", sr_inhibit, 1'b0);
    release_cs();
    chk("R8 pin low grant", g_sr, 1'b1);
    finish_cycle();
    chk("R8 applied", status_o, 8'h04);
    wp_level = 1'b1;
    do_wren();
    start_wrsr(8'h08);
    wp_level = 1'b0;
    @(negedge clk);
    chk("R8 fall no cancel", sr_inhibit, 1'b0);
    release_cs();
    chk("R8 fall grant", g_sr, 1'b1);
    finish_cycle();
    chk("R8 applied 2", status_o, 8'h08);
    wp_level = 1'b1;

    // R11 block-protect table
    for (int i = 0; i < 12; i++) begin
      logic blk;
      logic [1:0] bp;
      blk = VEC[i][15];
      bp  = VEC[i][14:13];
      write_status({4'b0000, bp, 2'b00});
      do_wren();
      start_mwr(VEC[i][12:0]);
      chk($sformatf("R11 inhibit vec%0d", i), mem_inhibit, blk);
      release_cs();
      chk($sformatf("R11 grant vec%0d", i), g_mem, !blk);
      if (g_mem) finish_cycle();
      chk($sformatf("R11 status vec%0d", i), status_o,
          {4'b0000, bp, blk, 1'b0});
      do_wrdi();
    end

    // R3 memory write without latch
    write_status(8'h00);
    start_mwr(13'h0010);
    chk("R3 mem inhibit", mem_inhibit, 1'b1);
    release_cs();
    chk("R3 mem no grant", g_mem, 1'b0);

    // R9 stray completion while idle
    finish_cycle();
    chk("R9 stray done", status_o, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule